// File: doc/BRIEF.md
# Three-Phase Gate Command Logic

This block sits between a PWM generator and the gate drivers of a three-phase bridge. It takes a high-side and a low-side command for each of the three legs, an enable and a gate-kill signal from the fault latch, and produces one high-side and one low-side gate enable per leg together with a two-bit leg state that says whether the leg output is driven to the bus, driven to ground, or left floating.

Every command and the enable pass through a two-flop synchronizer and a minimum-width filter, so short glitches never reach a gate. A command pair that asks for both switches of a leg at once is treated as a request to float the leg, so the block itself never allows shoot-through. All six command paths share one depth, giving every channel the same latency. The gate-kill input, already latched upstream, skips the filter so that a trip removes the gates as early as possible.

Top module: `three_phase_gate_cmd`

## Requirements
- R1: While rst_n is low, all six gate outputs are 0 and every leg state reads 2'b00 (floating).
- R2: With enable and no kill, high command 1 and low command 0 on a leg give high gate 1, low gate 0 and leg state 2'b01 (driven to bus).
- R3: High command 0 and low command 1 give high gate 0, low gate 1 and leg state 2'b10 (driven to ground).
- R4: High command 1 and low command 1 on the same leg give both gates 0 and leg state 2'b00.
- R5: Both commands 0 give both gates 0 and leg state 2'b00.
- R6: When the filtered enable is 0, all six gates are 0 whatever the commands.
- R7: A gate_kill level held high turns all gates off exactly 3 rising edges after it is applied, and commands have no effect while it stays high.
- R8: A command level that lasts fewer than PWM_FILT clock cycles never reaches the gates; one that lasts PWM_FILT cycles does.
- R9: An enable low pulse shorter than EN_FILT cycles leaves the gates unchanged.
- R10: A command change appears at the gate outputs exactly PWM_FILT+3 rising edges after it is applied, the same on all six channels.
- R11: A falling enable turns the gates off exactly EN_FILT+3 rising edges after it falls.
- R12: The high and low gates of one leg are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 3 | High-side PWM command, bit i for leg i, active high |
| lo_cmd | input | 3 | Low-side PWM command, bit i for leg i, active high |
| enable | input | 1 | Drive enable, active high |
| gate_kill | input | 1 | Trip from fault latch, active high |
| hi_gate | output | 3 | High-side gate enable per leg |
| lo_gate | output | 3 | Low-side gate enable per leg |
| leg_state | output | 6 | Leg state, bits [2i+1:2i] for leg i: 00 floating, 01 bus, 10 ground |

## Verification
The hardest situation to reach from the ports is a pulse that is exactly one cycle short of the filter length, since only a width of PWM_FILT-1 separates a filter that counts correctly from one that is off by one. The stimulus drives inputs at the falling edge and holds a level for an exact count of cycles, first PWM_FILT-1 and then PWM_FILT, watching the gate outputs every cycle. Latency is pinned by checking the outputs one edge before and at the edge where they must change, with all three legs receiving different command pairs in the same cycle.

// File: rtl/gate_cmd_pkg.sv
package gate_cmd_pkg;
  typedef enum logic [1:0] {
    LEG_FLOAT = 2'b00,
    LEG_BUS   = 2'b01,
    LEG_GND   = 2'b10
  } leg_state_t;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/min_width_filter.sv
module min_width_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    out_d  = out_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (din != out_q) begin
      if (cnt_q == LAST) begin
        out_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_change_follows_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> (out_q == $past(din)));
endmodule

// File: rtl/leg_drive.sv
module leg_drive
  import gate_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_f,
  input  logic       lo_f,
  input  logic       active,
  output logic       hi_gate,
  output logic       lo_gate,
  output logic [1:0] state
);
  logic       hi_q, hi_d;
  logic       lo_q, lo_d;
  leg_state_t st_q, st_d;

  always_comb begin
    hi_d = active & hi_f & ~lo_f;
    lo_d = active & lo_f & ~hi_f;
    if (hi_d)      st_d = LEG_BUS;
    else if (lo_d) st_d = LEG_GND;
    else           st_d = LEG_FLOAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      st_q <= LEG_FLOAT;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      st_q <= st_d;
    end
  end

  assign hi_gate = hi_q;
  assign lo_gate = lo_q;
  assign state   = st_q;

  assert_bus_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hi_f && !lo_f) |=> (hi_gate && !lo_gate && state == 2'b01));

  assert_float_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_f && lo_f) |=> (!hi_gate && !lo_gate && state == 2'b00));

  assert_no_shoot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));
endmodule

// File: rtl/three_phase_gate_cmd.sv
module three_phase_gate_cmd #(
  parameter int PWM_FILT = 4,
  parameter int EN_FILT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hi_cmd,
  input  logic [2:0] lo_cmd,
  input  logic       enable,
  input  logic       gate_kill,
  output logic [2:0] hi_gate,
  output logic [2:0] lo_gate,
  output logic [5:0] leg_state
);
  localparam int LEGS  = 3;
  localparam int NCMD  = 2 * LEGS;

  logic [NCMD-1:0] cmd_raw, cmd_s, cmd_f;
  logic            en_s, en_f, kill_s;
  logic            active;

  assign cmd_raw = {lo_cmd, hi_cmd};

  in_sync #(.W(NCMD + 2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({gate_kill, enable, cmd_raw}),
    .q    ({kill_s, en_s, cmd_s})
  );

  for (genvar c = 0; c < NCMD; c++) begin : g_cmd_filt
    min_width_filter #(.HOLD(PWM_FILT)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cmd_s[c]),
      .dout (cmd_f[c])
    );
  end

  min_width_filter #(.HOLD(EN_FILT)) u_en_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (en_s),
    .dout (en_f)
  );

  assign active = en_f & ~kill_s;

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    leg_drive u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_f   (cmd_f[l]),
      .lo_f   (cmd_f[LEGS + l]),
      .active (active),
      .hi_gate(hi_gate[l]),
      .lo_gate(lo_gate[l]),
      .state  (leg_state[2*l +: 2])
    );
  end

  assert_enable_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_f |=> (hi_gate == '0 && lo_gate == '0));

  assert_kill_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_s |=> (hi_gate == '0 && lo_gate == '0 && leg_state == '0));
endmodule

// File: tb/sim_three_phase_gate_cmd.sv
module sim_three_phase_gate_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int PF = 4;
  localparam int EF = 3;
  localparam int PWM_LAT = PF + 3;
  localparam int EN_LAT  = EF + 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hi_cmd, lo_cmd;
  logic       enable, gate_kill;
  logic [2:0] hi_gate, lo_gate;
  logic [5:0] leg_state;

  int checks = 0;
  int failures = 0;
  int shoot_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  three_phase_gate_cmd #(.PWM_FILT(PF), .EN_FILT(EF)) u0 (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .enable(enable), .gate_kill(gate_kill),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .leg_state(leg_state)
  );

  always @(negedge clk) if ((hi_gate & lo_gate) != 3'b000) shoot_seen++;

  task automatic expect_out(string req, logic [2:0] eh, logic [2:0] el, logic [5:0] es);
    checks++;
    if (hi_gate !== eh || lo_gate !== el || leg_state !== es) begin
      failures++;
      $display("FAIL %s: got hi=%b lo=%b st=%b expected hi=%b lo=%b st=%b",
               req, hi_gate, lo_gate, leg_state, eh, el, es);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; hi_cmd = 3'b111; lo_cmd = 3'b000; enable = 1'b1; gate_kill = 1'b0;
    wait_n(5);
    expect_out("R1 reset", 3'b000, 3'b000, 6'b000000);
    hi_cmd = 3'b000;
    rst_n = 1'b1;
    wait_n(12);
    expect_out("R5 idle after reset", 3'b000, 3'b000, 6'b000000);
  endtask

  task automatic t_mixed_legs;
    // leg0 bus, leg1 ground, leg2 both asserted
    hi_cmd = 3'b101; lo_cmd = 3'b110;
    wait_n(PWM_LAT - 1);
    expect_out("R10 not early", 3'b000, 3'b000, 6'b000000);
    wait_n(1);
    expect_out("R2 R3 R4 R10 mixed legs", 3'b001, 3'b010, 6'b00_10_01);
    // swap: leg0 ground, leg1 bus, leg2 both low
    hi_cmd = 3'b010; lo_cmd = 3'b001;
    wait_n(PWM_LAT - 1);
    expect_out("R10 hold before change", 3'b001, 3'b010, 6'b00_10_01);
    wait_n(1);
    expect_out("R2 R3 R5 R10 swapped legs", 3'b010, 3'b001, 6'b00_01_10);
  endtask

  task automatic t_glitch;
    int bad;
    bad = 0;
    hi_cmd[2] = 1'b1;
    wait_n(PF - 1);
    hi_cmd[2] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      wait_n(1);
      if (hi_gate[2] !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R8 short pulse: got %0d cycles with hi_gate[2]=1 expected 0", bad);
    end
    hi_cmd[2] = 1'b1;
    wait_n(PF);
    hi_cmd[2] = 1'b0;
    wait_n(PWM_LAT - PF);
    expect_out("R8 full width pulse", 3'b110, 3'b001, 6'b01_01_10);
    wait_n(PF);
    expect_out("R8 full width pulse end", 3'b010, 3'b001, 6'b00_01_10);
  endtask

  task automatic t_enable;
    int bad;
    bad = 0;
    enable = 1'b0;
    wait_n(EF - 1);
    enable = 1'b1;
    for (int i = 0; i < 12; i++) begin
      wait_n(1);
      if (hi_gate !== 3'b010 || lo_gate !== 3'b001) bad++;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R9 enable glitch: got %0d disturbed cycles expected 0", bad);
    end
    enable = 1'b0;
    wait_n(EN_LAT - 1);
    expect_out("R11 before enable off", 3'b010, 3'b001, 6'b00_01_10);
    wait_n(1);
    expect_out("R11 enable off", 3'b000, 3'b000, 6'b000000);
    hi_cmd = 3'b001; lo_cmd = 3'b100;
    wait_n(PWM_LAT + 4);
    expect_out("R6 disabled ignores commands", 3'b000, 3'b000, 6'b000000);
    enable = 1'b1;
    wait_n(EN_LAT);
    expect_out("R6 re-enable", 3'b001, 3'b100, 6'b10_00_01);
  endtask

  task automatic t_kill;
    gate_kill = 1'b1;
    wait_n(2);
    expect_out("R7 kill not early", 3'b001, 3'b100, 6'b10_00_01);
    wait_n(1);
    expect_out("R7 kill off", 3'b000, 3'b000, 6'b000000);
    hi_cmd = 3'b110; lo_cmd = 3'b001;
    wait_n(PWM_LAT + 4);
    expect_out("R7 killed ignores commands", 3'b000, 3'b000, 6'b000000);
    gate_kill = 1'b0;
    wait_n(3);
    expect_out("R7 kill released", 3'b110, 3'b001, 6'b01_01_10);
  endtask

  initial begin
    t_reset();
    t_mixed_legs();
    t_glitch();
    t_enable();
    t_kill();
    checks++;
    if (shoot_seen != 0) begin
      failures++;
      $display("FAIL R12 shoot-through: got %0d cycles expected 0", shoot_seen);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule